// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the integer data-processing stage of a 32-bit core. It takes two operands, an operation code, a set-flags request and the carry bit produced by an external operand shifter. From these it forms, in one combinational pass, a 32-bit result and a destination write-enable. A small register holds the four condition flags: negative, zero, carry and overflow.

The operations are bitwise logic, move and move-inverted, add and subtract, reverse subtract, the carry-chained forms of all three, compare and test, an upper-halfword insert, and a PC-relative address form. Add, subtract and reverse subtract share one adder. Subtraction feeds the adder an inverted operand, so a set carry flag after any subtraction means no borrow occurred. Logical operations take their carry from the shifter, or from the rotated immediate, and leave overflow untouched.

The flag register changes only on a clock edge where set-flags is asserted and the operation is one that defines flags. The flag word has N at bit 31, Z at bit 30, C at bit 29 and V at bit 28. Bits 27:0 of the word are never written by this block and hold zero.

Top module: `dp_alu`

## Requirements
- R1: An active-low synchronous reset clears the flag word to zero, and bits 27:0 of the flag word always read zero.
- R2: The flag word changes only on a rising edge where `set_flags_i` is high and the opcode is one of 0..17. In every other cycle it holds its value.
- R3: After a flag update, N (bit 31) equals bit 31 of the result and Z (bit 30) is set exactly when the 32-bit result is zero.
- R4: ADD (4), ADC (5) and CMN (11) compute a+b, plus the old C for ADC. C is the unsigned carry-out of that sum and V is its signed overflow.
- R5: SUB (2), SBC (6) and CMP (10) compute a-b, with SBC subtracting one more when the old C is clear. C is set when no borrow occurs and V is the signed overflow of the difference.
- R6: RSB (3) and RSC (7) compute b-a, with RSC subtracting one more when the old C is clear. C and V follow the same rules as in R5 with the operands swapped.
- R7: For the logical opcodes AND (0), EOR (1), TST (8), TEQ (9), ORR (12), ORN (13), MOV (14), BIC (15), MVN (16) and MOVT (17), V keeps its old value. With `imm_form_i` low, C takes `shift_carry_i`. With `imm_form_i` high, C takes bit 31 of `opb_i` when `imm_rot_nz_i` is high and keeps its old value otherwise.
- R8: The compare and test opcodes (8, 9, 10, 11) never assert `dest_we_o`. Every other opcode from 0 to 18 asserts it.
- R9: The logical results are: AND a&b, EOR a^b, ORR a|b, ORN a|~b, BIC a&~b, MOV b, MVN ~b, TST a&b, TEQ a^b.
- R10: MOVT (17) returns bits 15:0 of `opb_i` in result bits 31:16 and bits 15:0 of `old_dest_i` in result bits 15:0.
- R11: ADR (18) returns (`pc_i` with bits 1:0 cleared) plus `opb_i` when `adr_up_i` is high, or minus `opb_i` when it is low. It never changes the flags.
- R12: Opcodes 19..31 give a zero result, no write and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 5 | Operation code |
| set_flags_i | input | 1 | Request a flag update this cycle |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand (shifted register or rotated immediate) |
| old_dest_i | input | 32 | Current destination value, used by MOVT |
| pc_i | input | 32 | Program counter for ADR |
| adr_up_i | input | 1 | ADR direction: 1 adds, 0 subtracts |
| imm_form_i | input | 1 | Second operand is a rotated immediate |
| imm_rot_nz_i | input | 1 | Rotation of the immediate was nonzero |
| shift_carry_i | input | 1 | Carry-out of the external shifter |
| result_o | output | 32 | Operation result |
| dest_we_o | output | 1 | Destination write-enable |
| flags_o | output | 32 | Flag word: N 31, Z 30, C 29, V 28, zeros below |

## Verification
The hardest cases to reach from the ports are the carry-chained operations running on a known old carry, and signed overflow at the 0x7FFFFFFF/0x80000000 boundary. Uniform random operands rarely produce either. The stimulus therefore draws each operand from a biased pool of boundary values, zero, all-ones and equal pairs. It sets flags often enough that ADC, SBC and RSC see both values of the old carry. Directed cases cover the exact overflow edges, borrow from zero and the immediate-carry hold path.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

    localparam int DATA_W = 32;
    localparam int OP_W   = 5;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 5'd0,
        OP_EOR  = 5'd1,
        OP_SUB  = 5'd2,
        OP_RSB  = 5'd3,
        OP_ADD  = 5'd4,
        OP_ADC  = 5'd5,
        OP_SBC  = 5'd6,
        OP_RSC  = 5'd7,
        OP_TST  = 5'd8,
        OP_TEQ  = 5'd9,
        OP_CMP  = 5'd10,
        OP_CMN  = 5'd11,
        OP_ORR  = 5'd12,
        OP_ORN  = 5'd13,
        OP_MOV  = 5'd14,
        OP_BIC  = 5'd15,
        OP_MVN  = 5'd16,
        OP_MOVT = 5'd17,
        OP_ADR  = 5'd18
    } alu_op_e;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_LOGIC,
        CLS_ARITH,
        CLS_ADDR
    } op_class_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

endpackage

// File: rtl/dp_alu_adder.sv
module dp_alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W:0] full;

    always_comb begin
        full   = {1'b0, x_i} + {1'b0, y_i} + {{W{1'b0}}, cin_i};
        sum_o  = full[W-1:0];
        cout_o = full[W];
        // signed overflow: like-signed inputs, result sign differs
        ovf_o  = (x_i[W-1] == y_i[W-1]) && (full[W-1] != x_i[W-1]);
    end
endmodule

// File: rtl/dp_alu_logic.sv
module dp_alu_logic
    import dp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] old_dest_i,
    output logic [W-1:0] res_o
);
    localparam int HALF = W / 2;

    always_comb begin
        unique case (op_i)
            OP_AND, OP_TST: res_o = x_i & y_i;
            OP_EOR, OP_TEQ: res_o = x_i ^ y_i;
            OP_ORR:         res_o = x_i | y_i;
            OP_ORN:         res_o = x_i | ~y_i;
            OP_BIC:         res_o = x_i & ~y_i;
            OP_MOV:         res_o = y_i;
            OP_MVN:         res_o = ~y_i;
            OP_MOVT:        res_o = {y_i[HALF-1:0], old_dest_i[HALF-1:0]};
            default:        res_o = '0;
        endcase
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   op_i,
    input  logic         set_flags_i,
    input  logic [W-1:0] opa_i,
    input  logic [W-1:0] opb_i,
    input  logic [W-1:0] old_dest_i,
    input  logic [W-1:0] pc_i,
    input  logic         adr_up_i,
    input  logic         imm_form_i,
    input  logic         imm_rot_nz_i,
    input  logic         shift_carry_i,
    output logic [W-1:0] result_o,
    output logic         dest_we_o,
    output logic [W-1:0] flags_o
);
    localparam int LOW_W = W - 4;

    typedef struct packed {
        nzcv_t flg;
    } state_t;

    state_t    st_d, st_q;
    alu_op_e   op;
    op_class_e cls;

    logic [W-1:0] add_x, add_y, add_sum, logic_res;
    logic         add_cin, add_cout, add_ovf;
    logic [W-1:0] adr_base, adr_y, adr_sum;
    logic         adr_cin, adr_cout, adr_ovf;
    logic         is_test, upd_en, logic_c;

    assign op = alu_op_e'(op_i);

    dp_alu_adder #(.W(W)) u_arith (
        .x_i(add_x), .y_i(add_y), .cin_i(add_cin),
        .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
    );

    dp_alu_adder #(.W(W)) u_addr (
        .x_i(adr_base), .y_i(adr_y), .cin_i(adr_cin),
        .sum_o(adr_sum), .cout_o(adr_cout), .ovf_o(adr_ovf)
    );

    dp_alu_logic #(.W(W)) u_logic (
        .op_i(op), .x_i(opa_i), .y_i(opb_i),
        .old_dest_i(old_dest_i), .res_o(logic_res)
    );

    // operand steering for the shared adder and the address adder
    always_comb begin
        add_x   = opa_i;
        add_y   = opb_i;
        add_cin = 1'b0;
        cls     = CLS_LOGIC;
        unique case (op)
            OP_ADD, OP_CMN: cls = CLS_ARITH;
            OP_ADC: begin
                cls     = CLS_ARITH;
                add_cin = st_q.flg.c;
            end
            OP_SUB, OP_CMP: begin
                cls     = CLS_ARITH;
                add_y   = ~opb_i;
                add_cin = 1'b1;
            end
            OP_SBC: begin
                cls     = CLS_ARITH;
                add_y   = ~opb_i;
                add_cin = st_q.flg.c;
            end
            OP_RSB: begin
                cls     = CLS_ARITH;
                add_x   = opb_i;
                add_y   = ~opa_i;
                add_cin = 1'b1;
            end
            OP_RSC: begin
                cls     = CLS_ARITH;
                add_x   = opb_i;
                add_y   = ~opa_i;
                add_cin = st_q.flg.c;
            end
            OP_ADR: cls = CLS_ADDR;
            OP_AND, OP_EOR, OP_TST, OP_TEQ, OP_ORR, OP_ORN,
            OP_MOV, OP_BIC, OP_MVN, OP_MOVT: cls = CLS_LOGIC;
            default: cls = CLS_NONE;
        endcase

        adr_base = {pc_i[W-1:2], 2'b00};
        adr_y    = adr_up_i ? opb_i : ~opb_i;
        adr_cin  = ~adr_up_i;
    end

    // result, write-enable and next flags
    always_comb begin
        is_test = (op == OP_TST) || (op == OP_TEQ) ||
                  (op == OP_CMP) || (op == OP_CMN);

        unique case (cls)
            CLS_ARITH: result_o = add_sum;
            CLS_ADDR:  result_o = adr_sum;
            CLS_LOGIC: result_o = logic_res;
            default:   result_o = '0;
        endcase

        dest_we_o = (cls != CLS_NONE) && !is_test;
        upd_en    = set_flags_i && ((cls == CLS_ARITH) || (cls == CLS_LOGIC));

        if (imm_form_i) logic_c = imm_rot_nz_i ? opb_i[W-1] : st_q.flg.c;
        else            logic_c = shift_carry_i;

        st_d = st_q;
        if (upd_en) begin
            st_d.flg.n = result_o[W-1];
            st_d.flg.z = (result_o == '0);
            st_d.flg.c = (cls == CLS_ARITH) ? add_cout : logic_c;
            st_d.flg.v = (cls == CLS_ARITH) ? add_ovf  : st_q.flg.v;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = {st_q.flg.n, st_q.flg.z, st_q.flg.c, st_q.flg.v, {LOW_W{1'b0}}};

    // ---------------- assertions ----------------
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (flags_o == '0)) else $error("reset clear");  // R1

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags_i |=> $stable(flags_o)) else $error("flags hold");  // R2

    AST_ADR_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 5'd18) |=> $stable(flags_o)) else $error("adr flags");  // R11

    AST_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i && op_i <= 5'd17) |=>
            (flags_o[W-1] == $past(result_o[W-1])) &&
            (flags_o[W-2] == ($past(result_o) == '0))) else $error("nz");  // R3

    AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags_i && cls == CLS_LOGIC) |=> $stable(flags_o[W-4]))
        else $error("logic v");  // R7

    AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 5'd8 && op_i <= 5'd11) |-> !dest_we_o) else $error("test we");  // R8

    AST_UNUSED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 5'd18) |=> $stable(flags_o)) else $error("unused");  // R12

endmodule

// File: tb/dp_alu_tb.sv
module dp_alu_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  op;
    logic        sf, up, imf, rnz, shc;
    logic [31:0] a, b, od, pc;
    logic [31:0] result;
    logic        we;
    logic [31:0] flags;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [3:0] mflg;   // model n,z,c,v

    always #(CLK_PERIOD/2) clk = ~clk;

    dp_alu u_dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .set_flags_i(sf),
        .opa_i(a), .opb_i(b), .old_dest_i(od), .pc_i(pc),
        .adr_up_i(up), .imm_form_i(imf), .imm_rot_nz_i(rnz),
        .shift_carry_i(shc), .result_o(result), .dest_we_o(we),
        .flags_o(flags)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s op=%0d act=%h exp=%h", req, op, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [4:0] o);
        case (o)
            5'd4, 5'd5, 5'd11: return "R4";
            5'd2, 5'd6, 5'd10: return "R5";
            5'd3, 5'd7:        return "R6";
            5'd17:             return "R10";
            5'd18:             return "R11";
            default:           return (o > 5'd18) ? "R12" : "R9";
        endcase
    endfunction

    // reference model built from the requirements
    task automatic model(output logic [31:0] res, output logic mwe,
                         output logic [3:0] nf);
        longint unsigned ua, ub, t;
        longint sa, sb, st;
        logic cin, c, v, upd;
        bit arith;
        ua = {32'b0, a}; ub = {32'b0, b};
        sa = longint'($signed(a)); sb = longint'($signed(b));
        cin = mflg[1];
        arith = 0; upd = 1; c = 0; v = 0; res = '0;
        mwe = !(op >= 5'd8 && op <= 5'd11) && (op <= 5'd18);
        case (op)
            5'd0, 5'd8:  res = a & b;
            5'd1, 5'd9:  res = a ^ b;
            5'd12:       res = a | b;
            5'd13:       res = a | ~b;
            5'd14:       res = b;
            5'd15:       res = a & ~b;
            5'd16:       res = ~b;
            5'd17:       res = {b[15:0], od[15:0]};
            5'd4, 5'd5, 5'd11: begin
                longint unsigned k;
                k = (op == 5'd5) ? longint'(cin) : 0;
                arith = 1;
                t = ua + ub + k; res = t[31:0]; c = t[32];
                st = sa + sb + longint'(k);
                v = (st != longint'($signed(res)));
            end
            5'd2, 5'd6, 5'd10: begin
                longint unsigned k;
                k = (op == 5'd6) ? longint'(!cin) : 0;
                arith = 1;
                res = a - b - k[31:0]; c = (ua >= ub + k);
                st = sa - sb - longint'(k);
                v = (st != longint'($signed(res)));
            end
            5'd3, 5'd7: begin
                longint unsigned k;
                k = (op == 5'd7) ? longint'(!cin) : 0;
                arith = 1;
                res = b - a - k[31:0]; c = (ub >= ua + k);
                st = sb - sa - longint'(k);
                v = (st != longint'($signed(res)));
            end
            5'd18: begin
                res = up ? ({pc[31:2], 2'b00} + b) : ({pc[31:2], 2'b00} - b);
                upd = 0;
            end
            default: upd = 0;
        endcase
        if (!arith) begin
            c = imf ? (rnz ? b[31] : mflg[1]) : shc;
            v = mflg[0];
        end
        nf = mflg;
        if (sf && upd) nf = {res[31], res == 0, c, v};
    endtask

    // drive at negedge, check comb outputs, then flags after the next edge
    task automatic step(input logic [4:0] o, input logic s, input logic [31:0] ia,
                        input logic [31:0] ib, input logic iimf, input logic irnz,
                        input logic ishc, input logic iup);
        logic [31:0] er;
        logic ewe;
        logic [3:0] nf;
        @(negedge clk);
        chk("R2", flags, {mflg, 28'b0});  // also R3..R7 flag values, R1 low bits
        op = o; sf = s; a = ia; b = ib; imf = iimf; rnz = irnz; shc = ishc; up = iup;
        od = $urandom; pc = $urandom;
        #1;
        model(er, ewe, nf);
        chk(tag_of(o), result, er);
        chk("R8", {31'b0, we}, {31'b0, ewe});
        mflg = nf;
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 7))
            0: return 32'h0;
            1: return 32'hFFFF_FFFF;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'h1;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; op = 0; sf = 0; a = 0; b = 0; od = 0; pc = 0;
        up = 0; imf = 0; rnz = 0; shc = 0; mflg = 4'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", flags, 32'h0);
        rst_n = 1;

        // directed corners
        step(5'd4, 1, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0);          // R4 signed overflow
        step(5'd4, 1, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0);          // R4 carry, zero
        step(5'd5, 1, 32'h1, 32'h1, 0, 0, 0, 0);                  // R4 ADC with C=1
        step(5'd2, 1, 32'h0, 32'h1, 0, 0, 0, 0);                  // R5 borrow -> C=0
        step(5'd6, 1, 32'h5, 32'h5, 0, 0, 0, 0);                  // R5 SBC with C=0
        step(5'd10, 1, 32'h8000_0000, 32'h1, 0, 0, 0, 0);         // R5 CMP overflow
        step(5'd7, 1, 32'h3, 32'h3, 0, 0, 0, 0);                  // R6 RSC
        step(5'd3, 1, 32'h1, 32'h0, 0, 0, 0, 0);                  // R6 RSB borrow
        step(5'd0, 1, 32'hF0F0_0000, 32'h8000_0001, 1, 1, 0, 0);  // R7 imm rotated
        step(5'd14, 1, 32'h0, 32'h8000_0000, 1, 0, 0, 0);         // R7 imm unrotated keeps C
        step(5'd13, 1, 32'h0, 32'h0, 0, 0, 1, 0);                 // R7 shifter carry, R9 ORN
        step(5'd17, 0, 32'h0, 32'h1234_ABCD, 0, 0, 0, 0);         // R10
        step(5'd18, 1, 32'h0, 32'h10, 0, 0, 0, 1);                // R11 up
        step(5'd18, 1, 32'h0, 32'h10, 0, 0, 0, 0);                // R11 down
        step(5'd25, 1, 32'h1, 32'h2, 0, 0, 1, 0);                 // R12
        step(5'd9, 1, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0, 0, 0, 0);  // R8 TEQ no write

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] ra, rb;
            ra = pick();
            rb = ($urandom_range(0, 5) == 0) ? ra : pick();
            step(5'($urandom_range(0, 21)), 1'($urandom_range(0, 2) != 0), ra, rb,
                 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        @(negedge clk);
        chk("R2", flags, {mflg, 28'b0});
        rst_n = 0;
        @(negedge clk);
        chk("R1", flags, 32'h0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule